// File: doc/BRIEF.md
# Sequential Single-Step Shift Unit

This block shifts a 32-bit operand left, logically right or arithmetically right. It is meant for a multi-cycle processor that has no room for a full barrel shifter. It moves the working value by one bit position per clock. A left step is formed by adding the value to itself through an adder. A right step uses a small dedicated one-bit path that fills the vacated top bit with either zero or the sign bit. While the unit iterates, it raises `busy` so the surrounding control sequence can hold its state.

A request is a single-cycle `start` together with an operation code, the operand and a 5-bit shift amount. The unit accepts a request only while idle. A down-counter is loaded with the amount and counts once per step. When the count is used up, the result register is written and `done` pulses for one cycle. The result stays on `result` until the next request is accepted.

Top module: `iter_shifter`

## Requirements
- R1: While reset is held and after it is released, before any request, `busy` and `done` are low and `result` is zero.
- R2: Operation code 2'b00 shifts left by the amount, and zeros enter at bit 0.
- R3: Operation codes 2'b01 and 2'b11 shift logically right by the amount, and zeros enter at bit 31.
- R4: Operation code 2'b10 shifts arithmetically right by the amount, and each step copies bit 31 into the vacated top bit.
- R5: For an amount N of 1 or more, `busy` is high for exactly N consecutive cycles, starting in the cycle after `start` is sampled. `done` is high in the cycle after the last busy cycle, which is N+1 cycles after the start edge.
- R6: Each busy cycle moves the working value by exactly one bit position, so the step counter falls by one in every busy cycle.
- R7: `done` is a pulse one cycle wide, and `busy` and `done` are never high together.
- R8: A `start` that arrives while `busy` or `done` is high is ignored. It does not change the result, the timing of the current operation, or the idle state that follows.
- R9: `result` changes only in a cycle where `done` is high, and it keeps its value until the next accepted request completes.
- R10: An amount of zero produces `done` in the cycle after the start edge, with `result` equal to the operand and `busy` never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe, sampled only while idle |
| op | input | 2 | Operation: 00 left, 01 logical right, 10 arithmetic right, 11 logical right |
| operand | input | 32 | Value to shift |
| count | input | 5 | Shift amount, 0 to 31 |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Shifted value, held until the next completion |

## Verification
The hardest condition to reach from the ports is a second `start` that lands while a shift is in flight or in the single completion cycle. Ordinary back-to-back traffic never creates it, because a well-behaved master waits for `done` first. The stimulus therefore injects a conflicting request, with a different operand and amount, on a busy cycle partway through a long shift. It also raises `start` exactly in the `done` cycle. The bench then checks that the completion time, the result and the return to idle match the first request alone. Random operations and amounts, along with directed cases for amounts of 0, 1 and 31 and for negative operands under arithmetic shift, cover the fill rules.

// File: rtl/iter_shift_pkg.sv
package iter_shift_pkg;

  typedef enum logic [1:0] {
    SH_LEFT   = 2'b00,
    SH_LRIGHT = 2'b01,
    SH_ARIGHT = 2'b10,
    SH_LALT   = 2'b11
  } shift_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHIFT = 2'b01,
    ST_DONE  = 2'b10
  } shift_state_e;

endpackage

// File: rtl/iter_rst_sync.sv
module iter_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  // Assert asynchronously, release after STAGES clean edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/iter_shift_step.sv
module iter_shift_step
  import iter_shift_pkg::*;
#(
  parameter int WIDTH          = 32,
  parameter bit LEFT_VIA_ADDER = 1'b1
) (
  input  shift_op_e          op,
  input  logic [WIDTH-1:0]   din,
  output logic [WIDTH-1:0]   dout
);

  logic [WIDTH-1:0] left_val;
  logic [WIDTH-1:0] right_val;
  logic             top_fill;

  // Left step: x + x doubles the value, the carry out falls off the top.
  generate
    if (LEFT_VIA_ADDER) begin : g_left_add
      logic [WIDTH:0] sum;
      always_comb begin
        sum      = {1'b0, din} + {1'b0, din};
        left_val = sum[WIDTH-1:0];
      end
    end else begin : g_left_wire
      always_comb begin
        left_val = {din[WIDTH-2:0], 1'b0};
      end
    end
  endgenerate

  // Right step: dedicated one-bit path, fill chosen by operation.
  always_comb begin
    top_fill  = (op == SH_ARIGHT) ? din[WIDTH-1] : 1'b0;
    right_val = {top_fill, din[WIDTH-1:1]};
  end

  always_comb begin
    if (op == SH_LEFT) begin
      dout = left_val;
    end else begin
      dout = right_val;
    end
  end

  // R2 left step leaves bit 0 clear
  always_comb begin
    a_r2_left_zero_fill: assert (!(op == SH_LEFT) || (dout[0] == 1'b0));
  end

  // R4 arithmetic step keeps the sign bit
  always_comb begin
    a_r4_sign_kept: assert (!(op == SH_ARIGHT) || (dout[WIDTH-1] == din[WIDTH-1]));
  end

endmodule

// File: rtl/iter_shift_ctrl.sv
module iter_shift_ctrl
  import iter_shift_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             accept,
  output logic             zero_req,
  output logic             stepping,
  output logic             last_step,
  output logic             busy,
  output logic             done
);

  shift_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    accept    = start && (state_q == ST_IDLE);
    zero_req  = accept && (count == '0);
    stepping  = (state_q == ST_SHIFT);
    last_step = stepping && (cnt_q == CNT_W'(1));
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = (count == '0) ? ST_DONE : ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (cnt_q == CNT_W'(1)) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Counter next value and enable
  always_comb begin
    cnt_en = accept || stepping;
    if (accept) begin
      cnt_d = count;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q == ST_SHIFT);
  assign done = (state_q == ST_DONE);

  // R7 done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7 busy and done exclusive
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R6 one count consumed per busy cycle
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))));

  // R10 zero amount finishes at once
  a_r10_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (count == '0)) |=> done);

  // R5 nonzero amount enters busy
  a_r5_busy_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (count != '0)) |=> busy);

  // R8 request during busy does not cut the operation short
  a_r8_start_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  // R8 request during done returns to idle
  a_r8_start_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!busy && !done));

endmodule

// File: rtl/iter_shifter.sv
module iter_shifter
  import iter_shift_pkg::*;
#(
  parameter int WIDTH          = 32,
  parameter int CNT_W          = $clog2(WIDTH),
  parameter bit LEFT_VIA_ADDER = 1'b1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] operand,
  input  logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  logic             rst_n_int;
  logic             accept, zero_req, stepping, last_step;
  shift_op_e        op_q;
  logic [WIDTH-1:0] work_q, work_d, step_out;
  logic [WIDTH-1:0] result_q, result_d;
  logic             work_en, result_en;

  iter_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  iter_shift_ctrl #(
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start),
    .count     (count),
    .accept    (accept),
    .zero_req  (zero_req),
    .stepping  (stepping),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  iter_shift_step #(
    .WIDTH          (WIDTH),
    .LEFT_VIA_ADDER (LEFT_VIA_ADDER)
  ) u_step (
    .op   (op_q),
    .din  (work_q),
    .dout (step_out)
  );

  // Working value: loaded on accept, stepped while shifting
  always_comb begin
    work_en = accept || stepping;
    work_d  = accept ? operand : step_out;
  end

  // Result: written once per completed request
  always_comb begin
    result_en = zero_req || last_step;
    result_d  = zero_req ? operand : step_out;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      op_q <= SH_LEFT;
    end else if (accept) begin
      op_q <= shift_op_e'(op);
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      work_q <= '0;
    end else if (work_en) begin
      work_q <= work_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      result_q <= '0;
    end else if (result_en) begin
      result_q <= result_d;
    end
  end

  assign result = result_q;

  // R9 result moves only when done appears
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n_int)
    (result != $past(result)) |-> done);

  // R1 quiet outputs during reset
  always_comb begin
    if (!rst_n_int) begin
      a_r1_reset_quiet: assert (!busy && !done && (result == '0));
    end
  end

endmodule

// File: tb/sim_iter_shifter.sv
module sim_iter_shifter;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [31:0] operand;
  logic [4:0]  count;
  logic        busy;
  logic        done;
  logic [31:0] result;

  int checks;
  int fails;
  bit finished;

  iter_shifter u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .operand (operand),
    .count   (count),
    .busy    (busy),
    .done    (done),
    .result  (result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] v, input int n);
    logic [31:0] x;
    x = v;
    for (int i = 0; i < n; i++) begin
      case (o)
        2'b00:   x = {x[30:0], 1'b0};
        2'b10:   x = {x[31], x[31:1]};
        default: x = {1'b0, x[31:1]};
      endcase
    end
    return x;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string op_req(input logic [1:0] o, input int n);
    if (n == 0) return "R10";
    if (o == 2'b00) return "R2";
    if (o == 2'b10) return "R4";
    return "R3";
  endfunction

  // mid: inject a conflicting start on the second busy cycle (R8)
  // tail: raise start in the done cycle (R8)
  task automatic run(input logic [1:0] o, input logic [31:0] v, input int n,
                     input bit mid, input bit tail);
    int c;
    int busy_cycles;
    logic [31:0] exp;
    exp = model(o, v, n);
    busy_cycles = 0;
    @(negedge clk);
    op = o; operand = v; count = 5'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op = ~o; operand = ~v; count = 5'(n + 3);
    c = 1;
    while (!done && c < 80) begin
      if (busy) busy_cycles++;
      start = (mid && c == 2) ? 1'b1 : 1'b0;
      @(negedge clk);
      c++;
    end
    start = 1'b0;
    // R5 completion time and busy length
    check("R5", 32'(c), 32'(n + 1));
    check("R5", 32'(busy_cycles), 32'(n));
    check(op_req(o, n), result, exp);
    if (tail) begin
      start = 1'b1; operand = 32'h5A5A_1234; count = 5'd7;
    end
    @(negedge clk);
    start = 1'b0;
    check("R7", {31'd0, done}, 32'd0);
    check("R8", {31'd0, busy}, 32'd0);
    @(negedge clk);
    check("R8", {30'd0, busy, done}, 32'd0);
    check("R9", result, exp);
  endtask

  initial begin
    checks = 0; fails = 0; finished = 0;
    start = 0; op = 0; operand = 0; count = 0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", {30'd0, busy, done}, 32'd0);
    check("R1", result, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {30'd0, busy, done}, 32'd0);
    check("R1", result, 32'd0);

    // directed corners
    run(2'b00, 32'h8000_0001, 1, 0, 0);
    run(2'b00, 32'hFFFF_FFFF, 31, 0, 0);
    run(2'b01, 32'h8000_0000, 31, 0, 0);
    run(2'b11, 32'hF0F0_F0F0, 4, 0, 0);
    run(2'b10, 32'h8000_0000, 31, 0, 0);
    run(2'b10, 32'h9234_5678, 5, 0, 0);
    run(2'b10, 32'h7FFF_FFFF, 30, 0, 0);
    run(2'b01, 32'hDEAD_BEEF, 0, 0, 0);
    run(2'b10, 32'hCAFE_F00D, 0, 0, 1);
    run(2'b00, 32'h0000_00FF, 12, 1, 0);
    run(2'b10, 32'hA000_0003, 9, 1, 1);
    run(2'b01, 32'h1234_5678, 1, 0, 1);

    // random traffic
    for (int k = 0; k < 120; k++) begin
      logic [1:0]  ro;
      logic [31:0] rv;
      int          rn;
      ro = 2'($urandom_range(0, 3));
      rv = $urandom;
      rn = $urandom_range(0, 31);
      run(ro, rv, rn, (rn >= 3) && ($urandom_range(0, 3) == 0), $urandom_range(0, 3) == 0);
    end

    // R9 result stays put through idle cycles
    repeat (5) @(negedge clk);
    check("R9", result, model(u0_last_op, u0_last_val, u0_last_n));
    finished = 1;
  end

  // Track last request for the idle-hold check (bench-side copy of stimulus)
  logic [1:0]  u0_last_op;
  logic [31:0] u0_last_val;
  int          u0_last_n;
  always @(posedge clk) begin
    if (start && !busy && !done && rst_n) begin
      u0_last_op  <= op;
      u0_last_val <= operand;
      u0_last_n   <= int'(count);
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule